// File: doc/BRIEF.md
# Snooping Write-Back Invalidation Cache Controller

This block controls a small direct-mapped, write-back data cache for one processor on a shared, bus-based multiprocessor. Every line is in one of three states: invalid, shared (clean and read-only) or exclusive (the only copy, writable and dirty). The processor side is a request/ready handshake. The request is held until `cpu_ready` rises, and read data is valid in that same cycle.

On the bus side the controller requests the bus and waits for a grant. Each granted transaction is atomic. The controller issues read misses, write misses and victim write-backs. It also watches every transaction that other caches place on the bus. When another cache misses on a line held dirty here, this cache drives the line's data in place of memory and downgrades or drops its own copy. Snoops take the line store ahead of the processor, so the processor is held off for each snoop cycle.

Top module: `snoop_msi_cache`

## Requirements
- R1: After reset every line is invalid, no bus request is raised and no snoop data is driven.
- R2: The line index is the low log2(LINES) address bits and the tag is the rest. A read that misses raises `bus_req` with command 01 (read miss) and the full address. When granted it completes with `bus_fill_data` and leaves the line shared.
- R3: A write to a line that is invalid or shared raises command 10 (write miss) and does not complete before the grant. The line then holds the written data as exclusive. The command and address stay fixed until the grant.
- R4: Read hits on shared or exclusive lines and write hits on exclusive lines complete in the cycle of the request, with no bus request.
- R5: A miss whose line holds a different exclusive block first issues command 11 (write-back) with the victim's address and data, then the miss. A clean victim is dropped with no write-back.
- R6: A snooped write miss (`snp_cmd` 10) to a block held shared invalidates it without driving data, so the next access to it misses.
- R7: A snooped read miss (`snp_cmd` 01) to a block held exclusive raises `snp_flush` with the line's data in that cycle and leaves the line shared.
- R8: A snooped write miss to a block held exclusive raises `snp_flush` with the line's data and invalidates the line.
- R9: In any cycle with a non-idle `snp_cmd`, `cpu_ready` stays low and the processor request makes no progress.
- R10: Snooped write-backs (11), idle cycles and snoops whose tag differs from the resident line change no state and raise no `snp_flush`.
- R11: If a snoop takes away the exclusive copy of a victim while its write-back is still waiting for the grant, the write-back is withdrawn and the miss proceeds directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request valid, held until ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Processor word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | DATA_W | Read data, valid with cpu_ready on reads |
| bus_req | output | 1 | Bus request, held until granted |
| bus_gnt | input | 1 | Bus grant; the transaction completes in this cycle |
| bus_cmd | output | 2 | 00 idle, 01 read miss, 10 write miss, 11 write-back |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Write-back data |
| bus_fill_data | input | DATA_W | Fill data returned in the grant cycle |
| snp_cmd | input | 2 | Command seen from another cache, same encoding |
| snp_addr | input | ADDR_W | Address seen from another cache |
| snp_flush | output | 1 | This cache supplies the dirty line; memory is to be bypassed |
| snp_flush_data | output | DATA_W | Data supplied with snp_flush |

## Verification
The bench targets the upgrade of a shared line on a write. A design that counted that write as a hit would finish with no bus transaction, and the write would never be ordered on the bus. It also targets eviction. A design that skipped the dirty victim's write-back would lose data that a later read miss exposes. A design that wrote back clean victims would show an extra transaction. A snoop that steals a victim during a pending write-back must withdraw the write-back. Otherwise a stale write-back appears after the line was already supplied. Stall cycles under snoop are checked as well, because a design that let a processor hit through in such a cycle would return ready while the line was being changed.

// File: rtl/msi_pkg.sv
`timescale 1ns/1ps
package msi_pkg;
    typedef enum logic [1:0] {
        LS_INV = 2'd0,
        LS_SHR = 2'd1,
        LS_EXC = 2'd2
    } line_st_e;

    typedef enum logic [1:0] {
        BC_IDLE   = 2'd0,
        BC_RDMISS = 2'd1,
        BC_WRMISS = 2'd2,
        BC_WRBACK = 2'd3
    } bus_cmd_e;

    typedef enum logic [1:0] {
        CF_IDLE  = 2'd0,
        CF_WBACK = 2'd1,
        CF_MISS  = 2'd2
    } ctrl_fsm_e;
endpackage

// File: rtl/msi_line_array.sv
`timescale 1ns/1ps
module msi_line_array
    import msi_pkg::*;
#(
    parameter int LINES  = 4,
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    // processor-side read port
    input  logic [IDX_W-1:0]  ra_idx,
    output line_st_e          ra_state,
    output logic [TAG_W-1:0]  ra_tag,
    output logic [DATA_W-1:0] ra_data,
    // snoop-side read port
    input  logic [IDX_W-1:0]  rb_idx,
    output line_st_e          rb_state,
    output logic [TAG_W-1:0]  rb_tag,
    output logic [DATA_W-1:0] rb_data,
    // snoop state update (wins)
    input  logic              sw_en,
    input  logic [IDX_W-1:0]  sw_idx,
    input  line_st_e          sw_state,
    // processor-side full line update
    input  logic              cw_en,
    input  logic [IDX_W-1:0]  cw_idx,
    input  line_st_e          cw_state,
    input  logic [TAG_W-1:0]  cw_tag,
    input  logic [DATA_W-1:0] cw_data
);
    typedef struct {
        line_st_e          st  [LINES];
        logic [TAG_W-1:0]  tag [LINES];
        logic [DATA_W-1:0] dat [LINES];
    } arr_t;

    arr_t arr_d, arr_q;

    assign ra_state = arr_q.st[ra_idx];
    assign ra_tag   = arr_q.tag[ra_idx];
    assign ra_data  = arr_q.dat[ra_idx];
    assign rb_state = arr_q.st[rb_idx];
    assign rb_tag   = arr_q.tag[rb_idx];
    assign rb_data  = arr_q.dat[rb_idx];

    always_comb begin
        arr_d = arr_q;
        if (cw_en) begin
            arr_d.st[cw_idx]  = cw_state;
            arr_d.tag[cw_idx] = cw_tag;
            arr_d.dat[cw_idx] = cw_data;
        end
        if (sw_en) begin
            arr_d.st[sw_idx] = sw_state;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) begin
                arr_q.st[i]  <= LS_INV;
                arr_q.tag[i] <= '0;
                arr_q.dat[i] <= '0;
            end
        end else begin
            arr_q <= arr_d;
        end
    end

    // R9: the processor side never writes while a snoop owns the array
    assert_one_writer_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(sw_en && cw_en));

    // R8: a snoop-driven state change is visible on the next cycle
    assert_snoop_update_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sw_en |=> (arr_q.st[$past(sw_idx)] == $past(sw_state)));
endmodule

// File: rtl/msi_snoop_unit.sv
`timescale 1ns/1ps
module msi_snoop_unit
    import msi_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 16
) (
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic [IDX_W-1:0]  rb_idx,
    input  line_st_e          rb_state,
    input  logic [TAG_W-1:0]  rb_tag,
    input  logic [DATA_W-1:0] rb_data,
    output logic              snp_active,
    output logic              sw_en,
    output line_st_e          sw_state,
    output logic              flush,
    output logic [DATA_W-1:0] flush_data
);
    logic match;

    assign rb_idx     = snp_addr[IDX_W-1:0];
    assign match      = (rb_tag == snp_addr[ADDR_W-1:IDX_W]) && (rb_state != LS_INV);
    assign snp_active = (snp_cmd != BC_IDLE);
    assign flush_data = rb_data;

    always_comb begin
        sw_en    = 1'b0;
        sw_state = rb_state;
        flush    = 1'b0;
        if (match) begin
            unique case (snp_cmd)
                BC_RDMISS: begin
                    if (rb_state == LS_EXC) begin
                        flush    = 1'b1;
                        sw_en    = 1'b1;
                        sw_state = LS_SHR;
                    end
                end
                BC_WRMISS: begin
                    flush    = (rb_state == LS_EXC);
                    sw_en    = 1'b1;
                    sw_state = LS_INV;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/msi_cpu_ctrl.sv
`timescale 1ns/1ps
module msi_cpu_ctrl
    import msi_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              snp_active,
    output logic [IDX_W-1:0]  ra_idx,
    input  line_st_e          ra_state,
    input  logic [TAG_W-1:0]  ra_tag,
    input  logic [DATA_W-1:0] ra_data,
    output logic              cw_en,
    output line_st_e          cw_state,
    output logic [TAG_W-1:0]  cw_tag,
    output logic [DATA_W-1:0] cw_data,
    output logic              bus_req,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_gnt,
    input  logic [DATA_W-1:0] bus_fill_data
);
    typedef struct packed {
        ctrl_fsm_e fsm;
    } ctrl_t;

    ctrl_t c_d, c_q;

    logic [TAG_W-1:0] req_tag;
    logic             tag_eq, resident, hit_ok, dirty_victim, go;

    assign ra_idx       = cpu_addr[IDX_W-1:0];
    assign req_tag      = cpu_addr[ADDR_W-1:IDX_W];
    assign tag_eq       = (ra_tag == req_tag);
    assign resident     = tag_eq && (ra_state != LS_INV);
    assign hit_ok       = resident && (!cpu_we || ra_state == LS_EXC);
    assign dirty_victim = (ra_state == LS_EXC) && !tag_eq;
    assign go           = !snp_active;

    always_comb begin
        c_d       = c_q;
        cpu_ready = 1'b0;
        cpu_rdata = ra_data;
        bus_req   = 1'b0;
        bus_cmd   = BC_IDLE;
        bus_addr  = cpu_addr;
        bus_wdata = ra_data;
        cw_en     = 1'b0;
        cw_state  = LS_INV;
        cw_tag    = req_tag;
        cw_data   = cpu_wdata;
        unique case (c_q.fsm)
            CF_IDLE: begin
                if (cpu_req && go) begin
                    if (hit_ok) begin
                        cpu_ready = 1'b1;
                        if (cpu_we) begin
                            cw_en    = 1'b1;
                            cw_state = LS_EXC;
                        end
                    end else if (dirty_victim) begin
                        c_d.fsm = CF_WBACK;
                    end else begin
                        c_d.fsm = CF_MISS;
                    end
                end
            end
            CF_WBACK: begin
                if (dirty_victim) begin
                    bus_req  = 1'b1;
                    bus_cmd  = BC_WRBACK;
                    bus_addr = {ra_tag, ra_idx};
                    if (bus_gnt && go) begin
                        cw_en    = 1'b1;
                        cw_state = LS_INV;
                        cw_tag   = ra_tag;
                        cw_data  = ra_data;
                        c_d.fsm  = CF_MISS;
                    end
                end else if (go) begin
                    c_d.fsm = CF_MISS;
                end
            end
            CF_MISS: begin
                bus_req = 1'b1;
                bus_cmd = cpu_we ? BC_WRMISS : BC_RDMISS;
                if (bus_gnt && go) begin
                    cw_en     = 1'b1;
                    cw_state  = cpu_we ? LS_EXC : LS_SHR;
                    cw_data   = cpu_we ? cpu_wdata : bus_fill_data;
                    cpu_ready = 1'b1;
                    cpu_rdata = bus_fill_data;
                    c_d.fsm   = CF_IDLE;
                end
            end
            default: c_d.fsm = CF_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q.fsm <= CF_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    // R3: a pending miss keeps its command and address until granted
    assert_miss_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt && bus_cmd != BC_WRBACK)
            |=> (bus_req && $stable(bus_cmd) && $stable(bus_addr)));

    // R5: a granted write-back is followed by the miss, never by a second write-back
    assert_single_wb_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_gnt && bus_cmd == BC_WRBACK)
            |=> !(bus_req && bus_cmd == BC_WRBACK));
endmodule

// File: rtl/snoop_msi_cache.sv
`timescale 1ns/1ps
module snoop_msi_cache
    import msi_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int LINES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_fill_data,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_flush,
    output logic [DATA_W-1:0] snp_flush_data
);
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0]  ra_idx, rb_idx;
    line_st_e          ra_state, rb_state, sw_state, cw_state;
    logic [TAG_W-1:0]  ra_tag, rb_tag, cw_tag;
    logic [DATA_W-1:0] ra_data, rb_data, cw_data;
    logic              sw_en, cw_en, snp_active;

    msi_line_array #(
        .LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
    ) i_array (
        .clk(clk), .rst_n(rst_n),
        .ra_idx(ra_idx), .ra_state(ra_state), .ra_tag(ra_tag), .ra_data(ra_data),
        .rb_idx(rb_idx), .rb_state(rb_state), .rb_tag(rb_tag), .rb_data(rb_data),
        .sw_en(sw_en), .sw_idx(rb_idx), .sw_state(sw_state),
        .cw_en(cw_en), .cw_idx(ra_idx), .cw_state(cw_state),
        .cw_tag(cw_tag), .cw_data(cw_data)
    );

    msi_snoop_unit #(
        .ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
    ) i_snoop (
        .snp_cmd(snp_cmd), .snp_addr(snp_addr),
        .rb_idx(rb_idx), .rb_state(rb_state), .rb_tag(rb_tag), .rb_data(rb_data),
        .snp_active(snp_active), .sw_en(sw_en), .sw_state(sw_state),
        .flush(snp_flush), .flush_data(snp_flush_data)
    );

    msi_cpu_ctrl #(
        .ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
    ) i_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .snp_active(snp_active),
        .ra_idx(ra_idx), .ra_state(ra_state), .ra_tag(ra_tag), .ra_data(ra_data),
        .cw_en(cw_en), .cw_state(cw_state), .cw_tag(cw_tag), .cw_data(cw_data),
        .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_gnt(bus_gnt), .bus_fill_data(bus_fill_data)
    );

    // R7: data is only supplied for a snooped miss, and never with a processor completion
    assert_flush_on_miss_R7: assert property (@(posedge clk) disable iff (!rst_n)
        snp_flush |-> (!cpu_ready && (snp_cmd == BC_RDMISS || snp_cmd == BC_WRMISS)));
endmodule

// File: tb/test_snoop_msi_cache.sv
`timescale 1ns/1ps
module test_snoop_msi_cache;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [7:0]  cpu_addr = '0;
    logic [15:0] cpu_wdata = '0;
    logic        cpu_ready;
    logic [15:0] cpu_rdata;
    logic        bus_req;
    logic        bus_gnt = 1'b0;
    logic [1:0]  bus_cmd;
    logic [7:0]  bus_addr;
    logic [15:0] bus_wdata;
    logic [15:0] bus_fill_data = '0;
    logic [1:0]  snp_cmd = '0;
    logic [7:0]  snp_addr = '0;
    logic        snp_flush;
    logic [15:0] snp_flush_data;

    always #10 clk = ~clk;

    snoop_msi_cache i_snoop_msi_cache (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_fill_data(bus_fill_data),
        .snp_cmd(snp_cmd), .snp_addr(snp_addr),
        .snp_flush(snp_flush), .snp_flush_data(snp_flush_data)
    );

    int n_chk = 0;
    int n_fail = 0;

    // reference: per-line state 0 invalid, 1 shared, 2 exclusive
    int          m_st [4];
    int          m_tag [4];
    logic [15:0] m_dat [4];
    logic [15:0] mem [int];
    int          q_cmd [$];
    int          q_addr [$];
    logic [15:0] q_dat [$];

    function automatic logic [15:0] memrd(int a);
        if (mem.exists(a)) return mem[a];
        return 16'(a * 37 + 5);
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic snoop_eval(int cmd, int sa, string req);
        int i, t;
        bit match, expf;
        i = sa % 4;
        t = sa / 4;
        match = (m_st[i] != 0) && (m_tag[i] == t);
        expf  = match && (m_st[i] == 2) && (cmd == 1 || cmd == 2);
        chk(snp_flush == expf, {req, " flush"}, int'(snp_flush), int'(expf));
        if (expf) begin
            chk(snp_flush_data == m_dat[i], {req, " flush data"}, int'(snp_flush_data), int'(m_dat[i]));
            mem[sa] = m_dat[i];
        end
        if (match && cmd == 2) m_st[i] = 0;
        else if (expf && cmd == 1) m_st[i] = 1;
    endtask

    task automatic snoop_only(int cmd, int sa, bit stall, int ca, string req);
        @(negedge clk);
        snp_cmd  = 2'(cmd);
        snp_addr = 8'(sa);
        cpu_req  = stall;
        cpu_we   = 1'b0;
        cpu_addr = 8'(ca);
        bus_gnt  = 1'b0;
        #2;
        chk(cpu_ready == 1'b0, "R9 ready low under snoop", int'(cpu_ready), 0);
        chk(bus_req == 1'b0, {req, " no bus request"}, int'(bus_req), 0);
        snoop_eval(cmd, sa, req);
        @(negedge clk);
        snp_cmd = '0;
        cpu_req = 1'b0;
    endtask

    task automatic cpu_op(bit we, int addr, logic [15:0] wd, int gdelay,
                          int snp_at, int scmd, int saddr, string req);
        int idx, tg, waited, cyc, vold, vidx;
        bit hit, done, is_snp;
        logic [15:0] exp_rd;
        idx = addr % 4;
        tg  = addr / 4;
        hit = (m_st[idx] != 0) && (m_tag[idx] == tg) && (!we || m_st[idx] == 2);
        q_cmd.delete(); q_addr.delete(); q_dat.delete();
        if (!hit) begin
            if (m_st[idx] == 2 && m_tag[idx] != tg) begin
                q_cmd.push_back(3); q_addr.push_back(m_tag[idx] * 4 + idx); q_dat.push_back(m_dat[idx]);
            end
            q_cmd.push_back(we ? 2 : 1); q_addr.push_back(addr); q_dat.push_back('0);
        end
        waited = 0; done = 0; cyc = 0;
        while (!done && cyc < 60) begin
            @(negedge clk);
            cpu_req = 1'b1; cpu_we = we; cpu_addr = 8'(addr); cpu_wdata = wd;
            bus_gnt = 1'b0; snp_cmd = '0;
            is_snp = (cyc == snp_at);
            if (is_snp) begin
                snp_cmd = 2'(scmd); snp_addr = 8'(saddr);
            end
            #1;
            if (!is_snp && bus_req && waited >= gdelay) begin
                bus_gnt = 1'b1;
                bus_fill_data = memrd(int'(bus_addr));
            end
            if (bus_req) waited++;
            #1;
            if (bus_req) begin
                if (q_cmd.size() == 0) begin
                    chk(0, {req, " unexpected bus request"}, int'(bus_cmd), 0);
                end else begin
                    chk(int'(bus_cmd) == q_cmd[0], {req, " bus command"}, int'(bus_cmd), q_cmd[0]);
                    chk(int'(bus_addr) == q_addr[0], {req, " bus address"}, int'(bus_addr), q_addr[0]);
                    if (q_cmd[0] == 3)
                        chk(bus_wdata == q_dat[0], "R5 write-back data", int'(bus_wdata), int'(q_dat[0]));
                end
            end
            if (is_snp) begin
                chk(cpu_ready == 1'b0, "R9 ready low under snoop", int'(cpu_ready), 0);
                vidx = saddr % 4;
                vold = m_st[vidx];
                snoop_eval(scmd, saddr, "R11 snoop on victim");
                if (vold == 2 && m_st[vidx] != 2 && q_cmd.size() > 1 && q_cmd[0] == 3 && q_addr[0] == saddr) begin
                    void'(q_cmd.pop_front()); void'(q_addr.pop_front()); void'(q_dat.pop_front());
                end
            end else begin
                if (bus_gnt && bus_req && q_cmd.size() > 0) begin
                    if (q_cmd[0] == 3) begin
                        mem[q_addr[0]] = bus_wdata;
                        m_st[idx] = 0;
                    end
                    void'(q_cmd.pop_front()); void'(q_addr.pop_front()); void'(q_dat.pop_front());
                end
                if (cpu_ready) begin
                    chk(q_cmd.size() == 0, {req, " completed before bus work"}, q_cmd.size(), 0);
                    exp_rd = hit ? m_dat[idx] : memrd(addr);
                    if (!we)
                        chk(cpu_rdata == exp_rd, {req, " read data"}, int'(cpu_rdata), int'(exp_rd));
                    if (we) begin
                        m_st[idx] = 2; m_tag[idx] = tg; m_dat[idx] = wd;
                    end else if (!hit) begin
                        m_st[idx] = 1; m_tag[idx] = tg; m_dat[idx] = exp_rd;
                    end
                    done = 1;
                end
            end
            cyc++;
        end
        if (!done) chk(0, {req, " request never completed"}, cyc, 0);
        @(negedge clk);
        cpu_req = 1'b0; bus_gnt = 1'b0; snp_cmd = '0;
    endtask

    initial begin
        #4_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        finish_run();
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            m_st[i] = 0; m_tag[i] = 0; m_dat[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        chk(bus_req == 1'b0, "R1 no bus request after reset", int'(bus_req), 0);
        chk(snp_flush == 1'b0, "R1 no flush after reset", int'(snp_flush), 0);
        chk(cpu_ready == 1'b0, "R1 idle ready after reset", int'(cpu_ready), 0);

        // R1/R2: first access misses; read miss fills shared
        cpu_op(0, 'h10, '0, 2, -1, 0, 0, "R2 read miss");
        cpu_op(0, 'h10, '0, 0, -1, 0, 0, "R4 read hit shared");
        // R3: write to shared is a write miss
        cpu_op(1, 'h10, 16'hA5A5, 3, -1, 0, 0, "R3 write upgrade");
        cpu_op(1, 'h10, 16'h1234, 0, -1, 0, 0, "R4 write hit exclusive");
        cpu_op(0, 'h10, '0, 0, -1, 0, 0, "R4 read hit exclusive");
        // R7 with R9 stall
        snoop_only(1, 'h10, 1, 'h10, "R7 snooped read on dirty");
        cpu_op(0, 'h10, '0, 0, -1, 0, 0, "R7 line still readable");
        cpu_op(1, 'h10, 16'h0F0F, 1, -1, 0, 0, "R7 line now shared");
        // R8
        snoop_only(2, 'h10, 1, 'h10, "R8 snooped write on dirty");
        cpu_op(0, 'h10, '0, 1, -1, 0, 0, "R8 line invalid after");
        // R6
        cpu_op(0, 'h21, '0, 0, -1, 0, 0, "R2 read miss idx1");
        snoop_only(2, 'h21, 0, 0, "R6 snooped write on shared");
        cpu_op(0, 'h21, '0, 2, -1, 0, 0, "R6 line invalid after");
        // R10
        cpu_op(1, 'h22, 16'hBEEF, 0, -1, 0, 0, "R3 write miss idx2");
        snoop_only(3, 'h22, 1, 'h22, "R10 snooped write-back ignored");
        snoop_only(1, 'h26, 0, 0, "R10 other tag ignored");
        snoop_only(2, 'h2E, 0, 0, "R10 other tag write ignored");
        cpu_op(1, 'h22, 16'hCAFE, 0, -1, 0, 0, "R10 line kept exclusive");
        // R5 dirty and clean victims
        cpu_op(0, 'h2A, '0, 1, -1, 0, 0, "R5 dirty victim read");
        cpu_op(0, 'h22, '0, 1, -1, 0, 0, "R5 clean victim dropped");
        cpu_op(0, 'h22, '0, 0, -1, 0, 0, "R5 written-back value");
        // R11
        cpu_op(1, 'h33, 16'h7777, 0, -1, 0, 0, "R3 write miss idx3");
        cpu_op(0, 'h37, '0, 3, 2, 1, 'h33, "R11 victim taken by read snoop");
        cpu_op(1, 'h0B, 16'h5151, 0, -1, 0, 0, "R3 write over shared idx3");
        cpu_op(1, 'h03, 16'h6262, 4, 2, 2, 'h0B, "R11 victim taken by write snoop");
        cpu_op(1, 'h0F, 16'h9393, 2, -1, 0, 0, "R5 write with dirty victim");
        // mixed pattern
        for (int k = 0; k < 24; k++) begin
            cpu_op((k % 3) == 0, (k * 7 + 3) % 40, 16'(k * 257 + 9), k % 3, -1, 0, 0, "R5 mixed traffic");
            if ((k % 5) == 4) snoop_only(1 + (k % 2), (k * 7 + 3) % 40, 0, 0, "R7 mixed snoop");
        end
        finish_run();
    end
endmodule